// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

A full-duplex serial port that moves 8-bit characters least-significant bit first over one shared synchronization clock. There is no start bit, stop bit, parity bit or address bit. The transmitter changes its data output on falling edges of that clock, and the receiver samples its data input on rising edges. The clock idles high. Two sources can drive it. The first is an internal generator paced by a baud-rate tick, and its output is then driven onto the clock pin. The second is an external clock on the same pin, which is brought into the system clock domain through a synchronizer.

The transmitter and the receiver are separate units, and each has a holding register in front of its shift register. Software can write the next character while the current one is being shifted out, or read the previous character while the next one is arriving. When the next byte is already waiting at a character boundary, the internal clock runs on with no gap. When nothing is waiting, the clock stops after the eighth pulse and the data line keeps the level of the last bit sent.

Top module: `sync_serial_xcvr`

## Requirements
- R1: A character is sent as 8 bits, bit 0 first and bit 7 last. `sdata_out` changes only on the system cycle of a synchronization-clock falling edge, so each bit is held from one falling edge to the next.
- R2: When `clk_ext_sel`=0, the internal clock is used. `sclk_oe`=1, and each `baud_tick` during a transfer toggles `sclk_out`. Each character produces exactly 8 low pulses, and `sclk_out` is high whenever no transfer is running. Reset leaves `sclk_out`=1 and `sdata_out`=1.
- R3: After the eighth bit, `sdata_out` keeps the level of bit 7 until the next character starts.
- R4: On each rising edge with `rx_en`=1, the receiver samples `sdata_in` and assembles the byte with the first bit in bit 0. After the eighth rising edge, the byte appears on `rd_data` and `rx_full` goes to 1.
- R5: The transmit holding register is loaded by `wr_stb` with `tx_en`=1, which clears `tx_empty`. At the next falling edge between characters, the byte moves to the shifter and `tx_empty` returns to 1. A `wr_stb` with `tx_en`=0 is ignored, and nothing is then transmitted.
- R6: If the holding register is full when a character ends, the next character starts at the next `baud_tick` with no gap. Two back-to-back characters span exactly 31 tick intervals from the first falling edge to the last rising edge.
- R7: The internal clock starts a character only when `tx_en`=1 and `tx_empty`=0, or when `tx_en`=0, `rx_en`=1 and `rx_full`=0. Otherwise it stops after the eighth pulse and stays high.
- R8: If a character completes while `rx_full`=1 and there is no `rd_stb` in that cycle, `rx_ovr` goes to 1 and `rd_data` is left unchanged. `rd_stb` clears both `rx_full` and `rx_ovr`.
- R9: `tx_en`=0 forces `tx_empty` to 1 and abandons the character in progress. `rx_en`=0 leaves `rx_full`, `rx_ovr` and `rd_data` unchanged and discards any partly received bits.
- R10: When `clk_ext_sel`=1, `sclk_oe`=0 and `sclk_in` passes through a two-flop synchronizer. Its falling and rising edges become one-cycle strobes, which drive the transmitter and the receiver as in R1 and R4. The two strobes never occur together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_ext_sel | input | 1 | 0: internal clock driven out, 1: external clock on sclk_in |
| baud_tick | input | 1 | One-cycle pulse; each pulse is one half period of the internal clock |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| wr_stb | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_stb | input | 1 | Read acknowledge; clears rx_full and rx_ovr |
| sclk_in | input | 1 | External synchronization clock |
| sdata_in | input | 1 | Serial receive data |
| sclk_out | output | 1 | Internally generated synchronization clock |
| sclk_oe | output | 1 | Output enable for the clock pin |
| sdata_out | output | 1 | Serial transmit data |
| tx_empty | output | 1 | Transmit holding register can take a byte |
| rd_data | output | 8 | Last byte accepted by the receiver |
| rx_full | output | 1 | rd_data holds an unread byte |
| rx_ovr | output | 1 | A byte was lost because rd_data was unread |

## Verification
Some properties are checked on every cycle by assertions. The data line moves only on a falling-edge strobe, and the falling and rising strobes never coincide. The internal clock leaves its high level only through a falling strobe. A disabled transmitter reports empty, and a disabled receiver freezes its flags and data. An overrun keeps the stored byte. Other behaviour only the bench scenarios can show: the bit order on the wire, the pulse count per character, the gap-free 31-interval span of two back-to-back characters, and the clock stopping once the receive register fills in receive-only mode. The same holds for a write ignored while disabled leaving the line quiet, and for loopback through the synchronized external clock.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

  typedef enum logic {
    CLK_INT = 1'b0,
    CLK_EXT = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic fall;
    logic rise;
  } edge_pair_t;

  // Decide whether the internal clock may begin a new character.
  function automatic logic f_clock_go(input logic tx_on, input logic tx_hold_empty,
                                      input logic rx_on, input logic rx_hold_full);
    return (tx_on & ~tx_hold_empty) | (rx_on & ~tx_on & ~rx_hold_full);
  endfunction

  // Edge detection between two successive samples of a level.
  function automatic edge_pair_t f_edges(input logic prev_lvl, input logic cur_lvl);
    edge_pair_t e;
    e.fall = prev_lvl & ~cur_lvl;
    e.rise = ~prev_lvl & cur_lvl;
    return e;
  endfunction

endpackage

// File: rtl/sxc_clk_src.sv
module sxc_clk_src
  import sxc_pkg::*;
#(
  parameter int CHAR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic baud_tick,
  input  logic go,
  input  logic sclk_in,
  output logic sclk_out,
  output logic fall_stb,
  output logic rise_stb
);

  localparam int PC_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;

  function automatic logic [PC_W-1:0] f_next_pulse(input logic [PC_W-1:0] p);
    return (p == PC_W'(CHAR_W - 1)) ? '0 : p + 1'b1;
  endfunction

  clk_src_e src;
  assign src = clk_src_e'(ext_sel);

  // Internal generator
  logic            gen_q;
  logic [PC_W-1:0] pulse_q;
  logic            int_fall, int_rise;

  assign int_fall = baud_tick & gen_q & ((pulse_q != '0) | go);
  assign int_rise = baud_tick & ~gen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q   <= 1'b1;
      pulse_q <= '0;
    end else if (src == CLK_EXT) begin
      gen_q   <= 1'b1;
      pulse_q <= '0;
    end else if (int_fall) begin
      gen_q   <= 1'b0;
    end else if (int_rise) begin
      gen_q   <= 1'b1;
      pulse_q <= f_next_pulse(pulse_q);
    end
  end

  assign sclk_out = gen_q;

  // External clock synchronizer
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= sclk_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ext_prev_q <= 1'b1;
    else        ext_prev_q <= sync_q[SYNC_STAGES-1];
  end

  edge_pair_t ext_e;
  assign ext_e = f_edges(ext_prev_q, sync_q[SYNC_STAGES-1]);

  assign fall_stb = (src == CLK_EXT) ? ext_e.fall : int_fall;
  assign rise_stb = (src == CLK_EXT) ? ext_e.rise : int_rise;

endmodule

// File: rtl/sxc_tx.sv
module sxc_tx #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              fall_stb,
  output logic              sdata_out,
  output logic              tx_empty
);

  localparam int CNT_W = $clog2(CHAR_W + 1);

  logic [CHAR_W-1:0] hold_q;
  logic [CHAR_W-1:0] shift_q;
  logic [CNT_W-1:0]  sent_q;
  logic              sdo_q;
  logic              empty_q;
  logic              mid_char;

  // Between characters when no bit or all bits have gone out.
  assign mid_char = (sent_q != '0) && (sent_q != CNT_W'(CHAR_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      shift_q <= '0;
      sent_q  <= '0;
      sdo_q   <= 1'b1;
      empty_q <= 1'b1;
    end else if (!tx_en) begin
      empty_q <= 1'b1;
      sent_q  <= '0;
    end else begin
      if (fall_stb) begin
        if (mid_char) begin
          sdo_q   <= shift_q[0];
          shift_q <= shift_q >> 1;
          sent_q  <= sent_q + 1'b1;
        end else if (!empty_q) begin
          sdo_q   <= hold_q[0];
          shift_q <= hold_q >> 1;
          sent_q  <= CNT_W'(1);
          empty_q <= 1'b1;
        end else begin
          sent_q  <= '0;
        end
      end
      if (wr_stb) begin
        hold_q  <= wr_data;
        empty_q <= 1'b0;
      end
    end
  end

  assign sdata_out = sdo_q;
  assign tx_empty  = empty_q;

endmodule

// File: rtl/sxc_rx.sv
module sxc_rx #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rise_stb,
  input  logic              sdata_in,
  input  logic              rd_stb,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rx_full,
  output logic              rx_ovr,
  output logic              done
);

  localparam int PC_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;

  logic [CHAR_W-1:0] shift_q;
  logic [CHAR_W-1:0] data_q;
  logic [PC_W-1:0]   got_q;
  logic              full_q;
  logic              ovr_q;
  logic              last_bit;
  logic [CHAR_W-1:0] next_byte;

  assign last_bit  = (got_q == PC_W'(CHAR_W - 1));
  assign next_byte = {sdata_in, shift_q[CHAR_W-1:1]};
  assign done      = rx_en & rise_stb & last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      data_q  <= '0;
      got_q   <= '0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (rd_stb) begin
        full_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (!rx_en) begin
        got_q <= '0;
      end else if (rise_stb) begin
        shift_q <= next_byte;
        if (last_bit) begin
          got_q <= '0;
          if (full_q && !rd_stb) begin
            ovr_q <= 1'b1;
          end else begin
            data_q <= next_byte;
            full_q <= 1'b1;
          end
        end else begin
          got_q <= got_q + 1'b1;
        end
      end
    end
  end

  assign rd_data = data_q;
  assign rx_full = full_q;
  assign rx_ovr  = ovr_q;

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import sxc_pkg::*;
#(
  parameter int CHAR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_ext_sel,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic              sclk_in,
  input  logic              sdata_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              sdata_out,
  output logic              tx_empty,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rx_full,
  output logic              rx_ovr
);

  // Internal events, brought out by name for the checker.
  logic edge_fall;
  logic edge_rise;
  logic rx_done;
  logic clk_go;

  assign clk_go  = f_clock_go(tx_en, tx_empty, rx_en, rx_full);
  assign sclk_oe = (clk_src_e'(clk_ext_sel) == CLK_INT);

  sxc_clk_src #(
    .CHAR_W     (CHAR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_sel  (clk_ext_sel),
    .baud_tick(baud_tick),
    .go       (clk_go),
    .sclk_in  (sclk_in),
    .sclk_out (sclk_out),
    .fall_stb (edge_fall),
    .rise_stb (edge_rise)
  );

  sxc_tx #(
    .CHAR_W(CHAR_W)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .fall_stb (edge_fall),
    .sdata_out(sdata_out),
    .tx_empty (tx_empty)
  );

  sxc_rx #(
    .CHAR_W(CHAR_W)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .rise_stb(edge_rise),
    .sdata_in(sdata_in),
    .rd_stb  (rd_stb),
    .rd_data (rd_data),
    .rx_full (rx_full),
    .rx_ovr  (rx_ovr),
    .done    (rx_done)
  );

endmodule

// File: rtl/sxc_checker.sv
module sxc_checker #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_ext_sel,
  input logic              tx_en,
  input logic              rx_en,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic              sclk_out,
  input logic              sdata_out,
  input logic              tx_empty,
  input logic [CHAR_W-1:0] rd_data,
  input logic              rx_full,
  input logic              rx_ovr,
  input logic              edge_fall,
  input logic              edge_rise,
  input logic              rx_done
);

  AST_DATA_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_fall |=> $stable(sdata_out)); // R1

  AST_CLK_LEAVES_HIGH_BY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_ext_sel && sclk_out && !edge_fall) |=> sclk_out); // R2

  AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_en) |=> !tx_empty); // R5

  AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !rd_stb) |=> (rx_ovr && $stable(rd_data))); // R8

  AST_TX_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tx_empty); // R9

  AST_RX_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rd_stb) |=> ($stable(rd_data) && $stable(rx_full) && $stable(rx_ovr))); // R9

  AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(edge_fall && edge_rise)); // R10

endmodule

bind sync_serial_xcvr sxc_checker #(.CHAR_W(CHAR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_ext_sel(clk_ext_sel),
  .tx_en      (tx_en),
  .rx_en      (rx_en),
  .wr_stb     (wr_stb),
  .rd_stb     (rd_stb),
  .sclk_out   (sclk_out),
  .sdata_out  (sdata_out),
  .tx_empty   (tx_empty),
  .rd_data    (rd_data),
  .rx_full    (rx_full),
  .rx_ovr     (rx_ovr),
  .edge_fall  (edge_fall),
  .edge_rise  (edge_rise),
  .rx_done    (rx_done)
);

// File: tb/sync_serial_xcvr_tb.sv
module sync_serial_xcvr_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_ext_sel = 1'b0;
  logic       baud_tick = 1'b0;
  logic       tx_en = 1'b0;
  logic       rx_en = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_stb = 1'b0;
  logic       sclk_in = 1'b1;
  logic       sdata_in;
  logic       sclk_out, sclk_oe, sdata_out, tx_empty, rx_full, rx_ovr;
  logic [7:0] rd_data;

  // Slave data source for receive-only tests; loopback otherwise.
  logic       use_slave = 1'b0;
  logic       slave_bit = 1'b1;
  logic [7:0] slave_byte = '0;
  int         slave_idx = 0;
  logic       slave_prev = 1'b1;

  assign sdata_in = use_slave ? slave_bit : sdata_out;

  always #10 clk = ~clk; // 50 MHz

  sync_serial_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .clk_ext_sel(clk_ext_sel), .baud_tick(baud_tick),
    .tx_en(tx_en), .rx_en(rx_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdata_out(sdata_out),
    .tx_empty(tx_empty), .rd_data(rd_data), .rx_full(rx_full), .rx_ovr(rx_ovr)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // Baud tick: one pulse every 4 cycles while enabled.
  logic tick_en = 1'b0;
  int   tick_cnt = 0;
  always @(negedge clk) begin
    if (tick_en) begin
      tick_cnt  = (tick_cnt + 1) % 4;
      baud_tick = (tick_cnt == 0);
    end else begin
      baud_tick = 1'b0;
    end
  end

  // ---------------- Reference model (behavioural) ----------------
  logic       m_sclk, m_s1, m_s2, m_s3, m_sdo, m_empty, m_full, m_ovr;
  int         m_pulse, m_txb, m_rxb;
  logic [7:0] m_txbyte, m_hold, m_rxacc, m_rdr;
  logic       m_go, m_ifall, m_irise, m_efall, m_erise, m_f, m_r, m_keep, m_empty_was;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sclk = 1; m_s1 = 1; m_s2 = 1; m_s3 = 1; m_sdo = 1; m_empty = 1;
      m_full = 0; m_ovr = 0; m_pulse = 0; m_txb = 0; m_rxb = 0;
      m_txbyte = 0; m_hold = 0; m_rxacc = 0; m_rdr = 0;
    end else begin
      m_go    = (tx_en && !m_empty) || (rx_en && !tx_en && !m_full);
      m_ifall = baud_tick && m_sclk && (m_pulse != 0 || m_go);
      m_irise = baud_tick && !m_sclk;
      m_efall = m_s3 && !m_s2;
      m_erise = !m_s3 && m_s2;
      m_f = clk_ext_sel ? m_efall : m_ifall;
      m_r = clk_ext_sel ? m_erise : m_irise;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sclk_in;
      if (clk_ext_sel) begin m_sclk = 1; m_pulse = 0; end
      else if (m_ifall) m_sclk = 0;
      else if (m_irise) begin m_sclk = 1; m_pulse = (m_pulse + 1) % 8; end
      // transmitter
      m_empty_was = m_empty;
      if (!tx_en) begin
        m_empty = 1; m_txb = 0;
      end else begin
        if (m_f) begin
          if (m_txb >= 1 && m_txb <= 7) begin
            m_sdo = m_txbyte[m_txb]; m_txb++;
          end else if (!m_empty_was) begin
            m_txbyte = m_hold; m_sdo = m_hold[0]; m_txb = 1; m_empty = 1;
          end else m_txb = 0;
        end
        if (wr_stb) begin m_hold = wr_data; m_empty = 0; end
      end
      // receiver
      m_keep = m_full && !rd_stb;
      if (rd_stb) begin m_full = 0; m_ovr = 0; end
      if (!rx_en) m_rxb = 0;
      else if (m_r) begin
        if (m_rxb == 0) m_rxacc = 0;
        m_rxacc[m_rxb] = sdata_in;
        m_rxb++;
        if (m_rxb == 8) begin
          if (m_keep) m_ovr = 1;
          else begin m_rdr = m_rxacc; m_full = 1; end
          m_rxb = 0;
        end
      end
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (sclk_out !== m_sclk || sclk_oe !== !clk_ext_sel || sdata_out !== m_sdo ||
          tx_empty !== m_empty || rx_full !== m_full || rx_ovr !== m_ovr || rd_data !== m_rdr) begin
        n_fail++;
        if (sclk_out !== m_sclk || sclk_oe !== !clk_ext_sel)
          $display("FAIL R2 cyc %0d model sclk/oe: actual %0b/%0b expected %0b/%0b",
                   cyc, sclk_out, sclk_oe, m_sclk, !clk_ext_sel);
        if (sdata_out !== m_sdo)
          $display("FAIL R1 cyc %0d model sdata_out: actual %0b expected %0b", cyc, sdata_out, m_sdo);
        if (tx_empty !== m_empty)
          $display("FAIL R5 cyc %0d model tx_empty: actual %0b expected %0b", cyc, tx_empty, m_empty);
        if (rx_full !== m_full || rd_data !== m_rdr)
          $display("FAIL R4 cyc %0d model rx_full/rd_data: actual %0b/%0h expected %0b/%0h",
                   cyc, rx_full, rd_data, m_full, m_rdr);
        if (rx_ovr !== m_ovr)
          $display("FAIL R8 cyc %0d model rx_ovr: actual %0b expected %0b", cyc, rx_ovr, m_ovr);
      end
    end
  end

  // ---------------- Line monitor ----------------
  logic       mon_prev = 1'b1;
  int         falls = 0, first_fall = 0, last_rise = 0;
  logic [7:0] seq = '0;
  always @(negedge clk) begin
    if (mon_prev && !sclk_out) begin
      if (falls == 0) first_fall = cyc;
      if (falls < 8) seq[falls] = sdata_out;
      falls++;
    end
    if (!mon_prev && sclk_out) last_rise = cyc;
    mon_prev = sclk_out;
  end

  // Slave presents the next bit after each falling edge of the internal clock.
  always @(negedge clk) begin
    if (slave_prev && !sclk_out && slave_idx < 8) begin
      slave_bit = slave_byte[slave_idx];
      slave_idx++;
    end
    slave_prev = sclk_out;
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- Tasks ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk); wr_stb = 1'b1; wr_data = b;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic take_byte();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic wait_full();
    do @(negedge clk); while (!rx_full);
  endtask

  task automatic wait_loaded();
    do @(negedge clk); while (!tx_empty);
  endtask

  task automatic mon_clear();
    falls = 0; first_fall = 0; last_rise = 0; seq = '0;
  endtask

  task automatic ext_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      sclk_in = 1'b0; repeat (5) @(negedge clk);
      sclk_in = 1'b1; repeat (5) @(negedge clk);
    end
  endtask

  logic [7:0] cap_a, cap_b;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R2", "reset sclk_out", sclk_out, 1);
    chk("R2", "reset sclk_oe", sclk_oe, 1);
    chk("R2", "reset sdata_out", sdata_out, 1);
    chk("R5", "reset tx_empty", tx_empty, 1);
    chk("R4", "reset rx_full", rx_full, 0);
    chk("R8", "reset rx_ovr", rx_ovr, 0);

    // Single character over loopback, internal clock
    tx_en = 1'b1; rx_en = 1'b1; tick_en = 1'b1;
    mon_clear();
    put_byte(8'h35);
    wait_full();
    chk("R4", "received byte", rd_data, 8'h35);
    chk("R1", "bit order on wire", seq, 8'h35);
    chk("R2", "pulses per char", falls, 8);
    repeat (40) @(negedge clk);
    chk("R7", "clock idle high after char", sclk_out, 1);
    chk("R7", "no extra pulses", falls, 8);
    chk("R3", "line holds last bit", sdata_out, 0);
    chk("R5", "empty after load", tx_empty, 1);
    take_byte();

    // Back-to-back characters
    mon_clear();
    put_byte(8'h3C);
    wait_loaded();
    put_byte(8'hC3);
    wait_full(); cap_a = rd_data; take_byte();
    wait_full(); cap_b = rd_data; take_byte();
    repeat (40) @(negedge clk);
    chk("R6", "first byte", cap_a, 8'h3C);
    chk("R6", "second byte", cap_b, 8'hC3);
    chk("R6", "pulses for two chars", falls, 16);
    chk("R6", "span first fall to last rise", last_rise - first_fall, 124);
    chk("R3", "line holds bit 7 of second", sdata_out, 1);

    // Overrun
    put_byte(8'h11);
    wait_loaded();
    put_byte(8'h22);
    do @(negedge clk); while (!rx_ovr);
    chk("R8", "overrun keeps old byte", rd_data, 8'h11);
    chk("R8", "full during overrun", rx_full, 1);
    // Receiver disabled: flags and data frozen while traffic runs
    rx_en = 1'b0;
    put_byte(8'h44);
    repeat (100) @(negedge clk);
    chk("R9", "rx off keeps data", rd_data, 8'h11);
    chk("R9", "rx off keeps full", rx_full, 1);
    chk("R9", "rx off keeps ovr", rx_ovr, 1);
    take_byte();
    chk("R8", "read clears full", rx_full, 0);
    chk("R8", "read clears ovr", rx_ovr, 0);
    rx_en = 1'b1;

    // Transmit disable and ignored write
    tick_en = 1'b0;
    repeat (2) @(negedge clk);
    put_byte(8'h55);
    chk("R5", "write clears empty", tx_empty, 0);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R9", "tx off forces empty", tx_empty, 1);
    put_byte(8'h77);
    chk("R5", "write while off ignored", tx_empty, 1);
    tx_en = 1'b1;
    mon_clear();
    tick_en = 1'b1;
    repeat (60) @(negedge clk);
    chk("R5", "nothing sent after ignored write", falls, 0);

    // Receive-only with internal clock
    slave_byte = 8'h96; slave_idx = 0; use_slave = 1'b1;
    mon_clear();
    tx_en = 1'b0;
    wait_full();
    chk("R4", "receive-only byte", rd_data, 8'h96);
    chk("R7", "receive-only pulses", falls, 8);
    mon_clear();
    repeat (60) @(negedge clk);
    chk("R7", "clock stops while full", falls, 0);
    chk("R7", "clock high while full", sclk_out, 1);
    rx_en = 1'b0;
    take_byte();
    use_slave = 1'b0;

    // External clock with loopback
    tick_en = 1'b0;
    clk_ext_sel = 1'b1;
    tx_en = 1'b1; rx_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "oe off for external clock", sclk_oe, 0);
    chk("R10", "internal clock parked high", sclk_out, 1);
    put_byte(8'h6B);
    ext_pulses(8);
    repeat (10) @(negedge clk);
    chk("R10", "external byte received", rd_data, 8'h6B);
    chk("R10", "external full", rx_full, 1);
    chk("R10", "external tx empty", tx_empty, 1);
    chk("R3", "external line holds bit 7", sdata_out, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule